// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block keeps one small, direct-mapped, write-back data cache coherent with its peers on a shared, totally ordered snooping bus. It takes loads and stores from a processor, serves hits locally, and places read, read-exclusive, upgrade and writeback transactions on the bus when a line has to be fetched, upgraded or evicted. Each line carries one of four states: Invalid, Shared (clean, read-only, possibly held elsewhere), Exclusive (sole copy, clean) and Modified (sole copy, dirty).

At the same time it watches every transaction that other caches issue. It answers with a wired-OR "shared" indication, hands over dirty data when it holds a line Modified, and downgrades or invalidates its own copy. Because a read that no one else shares fills in Exclusive, a later store to that line completes with no bus traffic at all.

Each line holds one word. The line index is the low address bits and the tag is the rest. The bus is single-beat: a transaction completes in the cycle its grant is high.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1 and `bus_req` is 0. A load to any address then misses and issues a bus read, command code 1, with the load address.
- R2: A read fill takes the word on `bus_rdata` and returns it to the processor. The line becomes Exclusive when `bus_shared_in` is 0 in the grant cycle and Shared when it is 1.
- R3: A store that hits an Exclusive line completes with no bus request. Its response comes one cycle after acceptance, and the line becomes Modified.
- R4: Loads and stores that hit a Modified line complete locally one cycle after acceptance, and a load returns the last stored word.
- R5: A store that hits a Shared line issues an upgrade, command code 3, with the store address. After the grant the line is Modified and holds the stored word.
- R6: A store miss issues a read-exclusive, command code 2, with the store address. The line fills Modified with the store word.
- R7: On a miss whose victim line, at the same index (address bits [1:0] in the default configuration), is Modified, a writeback (command code 4) carrying the victim address and its dirty word is issued before the read or read-exclusive. A Shared or Exclusive victim is dropped with no bus transaction.
- R8: A snooped read (code 1) that hits a valid line raises `snoop_shared_out` in the same cycle. A Modified line also raises `snoop_flush` with its word on `snoop_data`. Modified or Exclusive lines become Shared. A tag mismatch or an Invalid line raises neither signal.
- R9: A snooped read-exclusive (2) or upgrade (3) that hits a valid line makes it Invalid. A Modified line first raises `snoop_flush` with its word, and the next access to that address misses.
- R10: `cpu_req_ready` is 0 while a bus transaction is pending and in any cycle with `snoop_valid` high. A request offered in such a cycle is not accepted.
- R11: If a pending upgrade loses its Shared copy to a snooped invalidation before the grant, the request goes out as a read-exclusive instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted at this edge when valid |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load data (store data echoed for stores) |
| bus_req | output | 1 | Bus transaction requested |
| bus_gnt | input | 1 | Transaction completes in this cycle |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| bus_shared_in | input | 1 | Wired-OR shared signal from other caches |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 3 | Snooped command, same codes as bus_cmd |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_shared_out | output | 1 | This cache holds the snooped address |
| snoop_flush | output | 1 | This cache supplies dirty data |
| snoop_data | output | DATA_W | Dirty word supplied on a flush |

## Verification
Hits answer on `cpu_resp_valid` exactly one cycle after the accepting edge. Misses and upgrades answer one cycle after the edge where the grant is sampled, and the bench's bus model counts the accept-to-response latency to tell the two apart. Snoop responses are combinational, so the bench samples them one time step after driving the snoop at a falling edge. The state change they cause is judged by the next processor or snoop access. Every bus transaction is logged at the falling edge where the grant is raised, and each access is checked against the expected count, order, commands, addresses and data.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE  = 3'd0,
        BC_READ  = 3'd1,
        BC_READX = 3'd2,
        BC_UPGR  = 3'd3,
        BC_WBACK = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_WBACK = 2'd1,
        CS_FETCH = 2'd2
    } ctl_st_e;

    typedef struct packed {
        logic     hit;
        logic     shared;
        logic     flush;
        line_st_e next;
    } snoop_act_t;

    function automatic logic holds_write(line_st_e s);
        return (s == LS_EXC) || (s == LS_MOD);
    endfunction

    function automatic logic is_valid(line_st_e s);
        return s != LS_INV;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 6,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_state,
    input  logic              wr_fill,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    line_st_e          st_q   [NUM_LINES];
    logic [TAG_W-1:0]  tag_q  [NUM_LINES];
    logic [DATA_W-1:0] data_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_LINES; k++) st_q[k] <= LS_INV;
        end else if (wr_en) begin
            st_q[wr_idx] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_fill) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snoop_valid,
    input  bus_cmd_e         snoop_cmd,
    input  logic [TAG_W-1:0] snoop_tag,
    input  line_st_e         line_state,
    input  logic [TAG_W-1:0] line_tag,
    output snoop_act_t       act
);

    logic match;

    assign match = snoop_valid && is_valid(line_state) && (line_tag == snoop_tag);

    always_comb begin
        act      = '0;
        act.next = line_state;
        if (match) begin
            case (snoop_cmd)
                BC_READ: begin
                    act.hit    = 1'b1;
                    act.shared = 1'b1;
                    act.flush  = (line_state == LS_MOD);
                    act.next   = LS_SHR;
                end
                BC_READX, BC_UPGR: begin
                    act.hit   = 1'b1;
                    act.flush = (line_state == LS_MOD);
                    act.next  = LS_INV;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_LINES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snoop_valid,
    input  logic [2:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_shared_out,
    output logic              snoop_flush,
    output logic [DATA_W-1:0] snoop_data
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_e           ctl_q;
    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  a_idx, b_idx, wr_idx;
    logic [TAG_W-1:0]  cur_tag, a_tag, b_tag, wr_tag;
    logic [DATA_W-1:0] a_data, b_data, wr_data;
    line_st_e          a_state, b_state, wr_state;
    logic              wr_en, wr_fill;
    logic              a_hit, accept, local_done, wb_live, granted;
    bus_cmd_e          cmd_e, fetch_cmd;
    snoop_act_t        snp;

    // Port A follows the processor address while idle, the held request otherwise.
    assign cur_addr = (ctl_q == CS_IDLE) ? cpu_req_addr : req_addr_q;
    assign a_idx    = cur_addr[IDX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    assign b_idx    = snoop_addr[IDX_W-1:0];

    mesi_line_store #(
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W)
    ) lines_i (
        .clk     (clk),
        .rst     (rst),
        .a_idx   (a_idx),
        .a_state (a_state),
        .a_tag   (a_tag),
        .a_data  (a_data),
        .b_idx   (b_idx),
        .b_state (b_state),
        .b_tag   (b_tag),
        .b_data  (b_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_state(wr_state),
        .wr_fill (wr_fill),
        .wr_tag  (wr_tag),
        .wr_data (wr_data)
    );

    mesi_snoop_unit #(
        .TAG_W(TAG_W)
    ) snoop_i (
        .snoop_valid(snoop_valid),
        .snoop_cmd  (bus_cmd_e'(snoop_cmd)),
        .snoop_tag  (snoop_addr[ADDR_W-1:IDX_W]),
        .line_state (b_state),
        .line_tag   (b_tag),
        .act        (snp)
    );

    assign snoop_shared_out = snp.shared;
    assign snoop_flush      = snp.flush;
    assign snoop_data       = b_data;

    // Processor side: snoops win the cycle, so no request is taken alongside one.
    assign a_hit         = is_valid(a_state) && (a_tag == cur_tag);
    assign cpu_req_ready = (ctl_q == CS_IDLE) && !snoop_valid;
    assign accept        = cpu_req_ready && cpu_req_valid;
    assign local_done    = a_hit && (!cpu_req_we || holds_write(a_state));

    // Bus side: the command for a pending request is re-evaluated every cycle,
    // so an upgrade whose Shared copy was snooped away turns into a read-exclusive.
    assign wb_live = (ctl_q == CS_WBACK) && (a_state == LS_MOD);

    always_comb begin
        if (!req_we_q)                                     fetch_cmd = BC_READ;
        else if (a_state == LS_SHR && a_tag == cur_tag)    fetch_cmd = BC_UPGR;
        else                                               fetch_cmd = BC_READX;
    end

    assign bus_req   = wb_live || (ctl_q == CS_FETCH);
    assign cmd_e     = wb_live ? BC_WBACK : ((ctl_q == CS_FETCH) ? fetch_cmd : BC_NONE);
    assign bus_cmd   = cmd_e;
    assign bus_addr  = wb_live ? {a_tag, a_idx} : req_addr_q;
    assign bus_wdata = wb_live ? a_data : '0;
    assign granted   = bus_req && bus_gnt;

    // Single line-store write port: snoop, then bus completion, then local store hit.
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = a_idx;
        wr_state = a_state;
        wr_fill  = 1'b0;
        wr_tag   = cur_tag;
        wr_data  = req_wdata_q;
        if (snp.hit) begin
            wr_en    = 1'b1;
            wr_idx   = b_idx;
            wr_state = snp.next;
        end else if (granted) begin
            wr_en = 1'b1;
            case (cmd_e)
                BC_WBACK: wr_state = LS_INV;
                BC_READ: begin
                    wr_state = bus_shared_in ? LS_SHR : LS_EXC;
                    wr_fill  = 1'b1;
                    wr_data  = bus_rdata;
                end
                default: begin
                    wr_state = LS_MOD;
                    wr_fill  = 1'b1;
                end
            endcase
        end else if (accept && cpu_req_we && local_done) begin
            wr_en    = 1'b1;
            wr_state = LS_MOD;
            wr_fill  = 1'b1;
            wr_data  = cpu_req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q        <= CS_IDLE;
            req_we_q     <= 1'b0;
            req_addr_q   <= '0;
            req_wdata_q  <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (ctl_q)
                CS_IDLE: begin
                    if (accept) begin
                        req_we_q    <= cpu_req_we;
                        req_addr_q  <= cpu_req_addr;
                        req_wdata_q <= cpu_req_wdata;
                        if (local_done) begin
                            resp_valid_q <= 1'b1;
                            resp_data_q  <= cpu_req_we ? cpu_req_wdata : a_data;
                        end else if (!a_hit && a_state == LS_MOD) begin
                            ctl_q <= CS_WBACK;
                        end else begin
                            ctl_q <= CS_FETCH;
                        end
                    end
                end
                CS_WBACK: begin
                    if (!wb_live || bus_gnt) ctl_q <= CS_FETCH;
                end
                CS_FETCH: begin
                    if (bus_gnt) begin
                        ctl_q        <= CS_IDLE;
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= req_we_q ? req_wdata_q : bus_rdata;
                    end
                end
                default: ctl_q <= CS_IDLE;
            endcase
        end
    end

    assign cpu_resp_valid = resp_valid_q;
    assign cpu_resp_rdata = resp_data_q;

    // A store hitting an Exclusive line finishes next cycle without the bus.
    assert_silent_store_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_req_we && a_hit && a_state == LS_EXC) |=> (cpu_resp_valid && !bus_req));

    // Every completed fetch or upgrade answers the processor on the next cycle.
    assert_resp_after_grant_R6: assert property (@(posedge clk) disable iff (rst)
        (granted && cmd_e != BC_WBACK) |=> cpu_resp_valid);

    // A dirty victim is never overwritten by a fetch.
    assert_no_fetch_over_dirty_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (cmd_e == BC_READ || cmd_e == BC_READX)) |-> (a_state != LS_MOD));

    // A snooped read to a held address always raises the shared signal.
    assert_snoop_read_shared_R8: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_cmd == 3'd1 && is_valid(b_state) &&
         b_tag == snoop_addr[ADDR_W-1:IDX_W]) |-> snoop_shared_out);

    // No new processor request while a transaction waits on the bus.
    assert_stall_on_bus_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cpu_req_ready);

endmodule

// File: tb/mesi_cache_ctrl_tb_top.sv
module mesi_cache_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    always #10 clk = ~clk;

    logic       cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
    logic [7:0] cpu_req_addr = '0, cpu_req_wdata = '0;
    logic       cpu_req_ready, cpu_resp_valid;
    logic [7:0] cpu_resp_rdata;
    logic       bus_req, bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic [2:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic       snoop_valid = 1'b0;
    logic [2:0] snoop_cmd = '0;
    logic [7:0] snoop_addr = '0;
    logic       snoop_shared_out, snoop_flush;
    logic [7:0] snoop_data;

    mesi_cache_ctrl dut_i (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mem [256];
    int  gnt_delay = 1, wait_cnt = 0;
    logic shared_drive = 1'b0;
    logic [2:0] log_cmd [8];
    logic [7:0] log_addr [8], log_data [8];
    int  log_n = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bus model: grants after gnt_delay waiting cycles, logs every transaction.
    always @(negedge clk) begin
        if (rst) begin
            bus_gnt = 1'b0; wait_cnt = 0;
        end else if (bus_gnt) begin
            bus_gnt = 1'b0; wait_cnt = 0;
        end else if (bus_req) begin
            if (wait_cnt >= gnt_delay) begin
                bus_gnt = 1'b1;
                bus_rdata = mem[bus_addr];
                bus_shared_in = shared_drive;
                if (log_n < 8) begin
                    log_cmd[log_n] = bus_cmd; log_addr[log_n] = bus_addr; log_data[log_n] = bus_wdata;
                end
                log_n++;
                if (bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
            end else wait_cnt++;
        end
    end

    bit stall_bad;
    task automatic cpu_op(input logic we, input logic [7:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        log_n = 0;
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr; cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        lat = 0;
        stall_bad = 0;
        do begin
            @(negedge clk);
            lat++;
            if (bus_req && cpu_req_ready) stall_bad = 1;
        end while (!cpu_resp_valid && lat < 50);
        rd = cpu_resp_rdata;
        chk(!stall_bad, "R10", "ready low during bus wait", stall_bad, 0);
    endtask

    task automatic snoop(input logic [2:0] cmd, input logic [7:0] addr,
                         output logic sh, output logic fl, output logic [7:0] d);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_cmd = cmd; snoop_addr = addr;
        #1;
        sh = snoop_shared_out; fl = snoop_flush; d = snoop_data;
        if (fl) mem[addr] = d;
        @(posedge clk);
        #1 snoop_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, a, wd, sd;
        logic       sh, fl;
        int         lat;
        logic [7:0] prev_a [4], prev_d [4];

        for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'h5A;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cpu_req_ready == 1'b1, "R1", "ready after reset", cpu_req_ready, 1);
        chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
        chk(cpu_resp_valid == 1'b0, "R1", "resp after reset", cpu_resp_valid, 0);

        // Sweep: every index, four rounds, shared signal alternating.
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                a  = {6'(8 * s + i + 1), 2'(i)};
                wd = 8'(8'hA0 + 16 * s + i);
                shared_drive = s[0];
                cpu_op(1'b0, a, 8'h00, rd, lat);
                chk(rd == (a ^ 8'h5A), "R2", "fill data", rd, a ^ 8'h5A);
                if (s == 0) begin
                    chk(log_n == 1 && log_cmd[0] == 3'd1 && log_addr[0] == a, "R1", "first miss read", log_addr[0], a);
                end else begin
                    chk(log_n == 2, "R7", "dirty eviction txn count", log_n, 2);
                    chk(log_cmd[0] == 3'd4 && log_addr[0] == prev_a[i] && log_data[0] == prev_d[i],
                        "R7", "writeback victim", log_data[0], prev_d[i]);
                    chk(log_cmd[1] == 3'd1 && log_addr[1] == a, "R7", "read after writeback", log_cmd[1], 1);
                end
                cpu_op(1'b1, a, wd, rd, lat);
                if (s[0]) begin
                    chk(log_n == 1 && log_cmd[0] == 3'd3 && log_addr[0] == a, "R5", "upgrade on shared", log_cmd[0], 3);
                end else begin
                    chk(log_n == 0 && lat == 1, "R3", "silent E store", lat, 1);
                end
                cpu_op(1'b0, a, 8'h00, rd, lat);
                chk(rd == wd && log_n == 0 && lat == 1, "R4", "load hit M", rd, wd);
                cpu_op(1'b1, a, wd ^ 8'hFF, rd, lat);
                chk(log_n == 0 && lat == 1, "R4", "store hit M", log_n, 0);
                prev_a[i] = a; prev_d[i] = wd ^ 8'hFF;
            end
        end

        // Snoop behaviour on index 0 (held Modified).
        shared_drive = 1'b0;
        snoop(3'd1, prev_a[0], sh, fl, sd);
        chk(sh && fl && sd == prev_d[0], "R8", "snoop read on M flushes", sd, prev_d[0]);
        snoop(3'd1, prev_a[0], sh, fl, sd);
        chk(sh && !fl, "R8", "snoop read on S", {sh, fl}, 2);
        snoop(3'd1, {6'd60, 2'd0}, sh, fl, sd);
        chk(!sh && !fl, "R8", "snoop tag mismatch", {sh, fl}, 0);
        cpu_op(1'b1, prev_a[0], 8'h33, rd, lat);
        chk(log_n == 1 && log_cmd[0] == 3'd3, "R5", "store after downgrade upgrades", log_cmd[0], 3);
        snoop(3'd2, prev_a[0], sh, fl, sd);
        chk(!sh && fl && sd == 8'h33, "R9", "snoop rdx on M flushes", sd, 8'h33);
        cpu_op(1'b0, prev_a[0], 8'h00, rd, lat);
        chk(log_n == 1 && log_cmd[0] == 3'd1 && rd == 8'h33, "R9", "miss after invalidation", rd, 8'h33);
        snoop(3'd1, prev_a[0], sh, fl, sd);
        chk(sh && !fl, "R8", "snoop read on E", {sh, fl}, 2);
        snoop(3'd3, prev_a[0], sh, fl, sd);
        chk(!sh && !fl, "R9", "snoop upgrade on S", {sh, fl}, 0);
        cpu_op(1'b0, prev_a[0], 8'h00, rd, lat);
        chk(log_n == 1 && log_cmd[0] == 3'd1, "R9", "miss after upgrade snoop", log_cmd[0], 1);

        // Store miss over a Modified victim (index 1).
        cpu_op(1'b1, {6'd40, 2'd1}, 8'h77, rd, lat);
        chk(log_n == 2 && log_cmd[0] == 3'd4 && log_cmd[1] == 3'd2 && log_addr[1] == {6'd40, 2'd1},
            "R6", "store miss writeback then rdx", log_cmd[1], 2);
        cpu_op(1'b0, {6'd40, 2'd1}, 8'h00, rd, lat);
        chk(rd == 8'h77 && log_n == 0, "R6", "rdx fill holds store", rd, 8'h77);
        cpu_op(1'b1, {6'd40, 2'd1}, 8'h78, rd, lat);
        chk(log_n == 0, "R6", "rdx fill is M", log_n, 0);

        // Shared victim dropped silently (index 2).
        snoop(3'd1, prev_a[2], sh, fl, sd);
        cpu_op(1'b0, {6'd41, 2'd2}, 8'h00, rd, lat);
        chk(log_n == 1 && log_cmd[0] == 3'd1, "R7", "S victim silent", log_n, 1);
        cpu_op(1'b1, {6'd41, 2'd2}, 8'h12, rd, lat);
        chk(log_n == 0 && lat == 1, "R3", "store on E fill", log_n, 0);

        // Exclusive victim dropped silently (index 3).
        snoop(3'd2, prev_a[3], sh, fl, sd);
        cpu_op(1'b0, prev_a[3], 8'h00, rd, lat);
        cpu_op(1'b1, {6'd42, 2'd3}, 8'h21, rd, lat);
        chk(log_n == 1 && log_cmd[0] == 3'd2, "R7", "E victim silent", log_n, 1);

        // Snoop blocks acceptance.
        @(negedge clk);
        snoop_valid = 1'b1; snoop_cmd = 3'd1; snoop_addr = {6'd50, 2'd2};
        cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = {6'd41, 2'd2};
        #1 chk(cpu_req_ready == 1'b0, "R10", "ready low under snoop", cpu_req_ready, 0);
        @(posedge clk);
        #1 snoop_valid = 1'b0; cpu_req_valid = 1'b0;
        @(negedge clk);
        chk(cpu_resp_valid == 1'b0, "R10", "request not taken under snoop", cpu_resp_valid, 0);

        // Pending upgrade loses its copy and becomes read-exclusive.
        snoop(3'd1, prev_a[0], sh, fl, sd);
        gnt_delay = 4;
        fork
            cpu_op(1'b1, prev_a[0], 8'h99, rd, lat);
            begin
                repeat (2) @(negedge clk);
                snoop(3'd2, prev_a[0], sh, fl, sd);
            end
        join
        chk(log_n == 1 && log_cmd[0] == 3'd2, "R11", "upgrade converted", log_cmd[0], 2);
        chk(!fl, "R11", "no flush from S", fl, 0);
        gnt_delay = 1;
        cpu_op(1'b0, prev_a[0], 8'h00, rd, lat);
        chk(rd == 8'h99 && log_n == 0, "R11", "line M after rdx", rd, 8'h99);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule